// File: doc/BRIEF.md
# Flash Erase-Suspend Controller

This block sits beside a flash erase engine and decides when a running auto-erase must be held so that the processor can reach the flash array, and when the erase may continue. It tracks three states: idle, erasing and suspended. A start strobe from the engine begins an erase and a done strobe ends it.

A single request bit drives the suspension. In the software-driven mode (EW0), only software sets this bit. In the interrupt-driven mode (EW1), an enabled interrupt that is pending during an erase also sets it. A suspend happens only when the suspend-enable input is high. Clearing the request bit while suspended lets the erase continue. The block drives a pause line to the engine, a status bit and a flash-access-allowed flag. The status bit reads 0 while the erase runs and 1 otherwise.

Top module: `erase_susp_ctrl`

## Requirements
- R1: After reset the controller is idle: `pause_o`=0, `susp_stat_o`=1, `flash_acc_ok_o`=1 and `req_bit_o`=0.
- R2: In idle, `erase_start_i` moves to erasing at the next edge (`susp_stat_o`=0, `flash_acc_ok_o`=0). In erasing, `erase_done_i` returns to idle at the next edge, and it takes precedence over a suspend request in the same cycle. `erase_done_i` in idle has no effect.
- R3: With `mode_ew1_i`=0 (EW0) and `susp_en_i`=1, writing 1 to the request bit (`req_wr_en_i`=1, `req_wr_val_i`=1) while erasing gives `pause_o`=1, `susp_stat_o`=1 and `flash_acc_ok_o`=1 at the next edge.
- R4: With `mode_ew1_i`=1 (EW1) and `susp_en_i`=1, `irq_pend_i`=1 while erasing sets `req_bit_o` to 1 and suspends at the next edge.
- R5: While suspended, writing 0 to the request bit returns to erasing at the next edge (`pause_o`=0, `susp_stat_o`=0).
- R6: While `susp_en_i`=0, neither a software write of 1 nor an interrupt suspends the erase. A software write still updates `req_bit_o`, and an interrupt does not set it.
- R7: A request bit write made in idle changes no state. `req_bit_o` still takes the written value, and an interrupt in idle does not set it.
- R8: With `mode_ew1_i`=0, `irq_pend_i` has no effect on `req_bit_o` or on the state.
- R9: While suspended, `erase_done_i` and `erase_start_i` are ignored. The controller stays suspended until the request bit is cleared.
- R10: When an interrupt sets the request bit and software writes 0 to it in the same cycle, the hardware set wins: `req_bit_o`=1 and the controller suspends.
- R11: `pause_o` is high only while suspended, so `pause_o`=1 always comes with `susp_stat_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| susp_en_i | input | 1 | Suspend function enable |
| mode_ew1_i | input | 1 | 1 = interrupt-driven mode (EW1), 0 = software-driven mode (EW0) |
| req_wr_en_i | input | 1 | Software write strobe for the request bit |
| req_wr_val_i | input | 1 | Value written to the request bit |
| irq_pend_i | input | 1 | An enabled interrupt request is pending |
| erase_start_i | input | 1 | Erase engine began an auto-erase |
| erase_done_i | input | 1 | Erase engine finished the auto-erase |
| pause_o | output | 1 | Hold request to the erase engine |
| susp_stat_o | output | 1 | 0 while erasing, 1 otherwise |
| flash_acc_ok_o | output | 1 | Flash may be accessed |
| req_bit_o | output | 1 | Current value of the request bit |

## Verification
The main stimulus is one continuous vector sequence. It suspends an erase through a software write and then through an interrupt, and resumes it with a clear after each. Repeating the same write or interrupt with the enable low, in EW0 mode, or in idle separates a request that actually suspends from one that only updates the bit or is dropped. Cycles where two inputs collide check the precedence rules: done against suspend, hardware set against a software clear, and done or start while suspended. Directed tests then check the reset state and a reset applied mid-suspend.

// File: rtl/esc_pkg.sv
package esc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_SUSP  = 2'd2
    } esc_state_e;

    typedef struct packed {
        esc_state_e st;
    } fsm_regs_t;

    typedef struct packed {
        logic req;
    } req_regs_t;
endpackage

// File: rtl/esc_req_reg.sv
module esc_req_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_val_i,
    input  logic hw_set_i,
    output logic req_next_o,
    output logic set_evt_o,
    output logic req_q_o
);
    import esc_pkg::*;

    req_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) r_d.req = wr_val_i;
        // an interrupt-raised set outranks a software clear
        if (hw_set_i) r_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_next_o = r_d.req;
    assign set_evt_o  = hw_set_i | (wr_en_i & wr_val_i);
    assign req_q_o    = r_q.req;
endmodule

// File: rtl/esc_fsm.sv
module esc_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                done_i,
    input  logic                susp_en_i,
    input  logic                set_evt_i,
    input  logic                req_next_i,
    output esc_pkg::esc_state_e state_o
);
    import esc_pkg::*;

    fsm_regs_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            ST_IDLE:  if (start_i) f_d.st = ST_ERASE;
            ST_ERASE: begin
                if (done_i)                      f_d.st = ST_IDLE;
                else if (susp_en_i && set_evt_i) f_d.st = ST_SUSP;
            end
            ST_SUSP:  if (!req_next_i) f_d.st = ST_ERASE;
            default:  f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q.st <= ST_IDLE;
        else        f_q <= f_d;
    end

    assign state_o = f_q.st;
endmodule

// File: rtl/erase_susp_ctrl.sv
module erase_susp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_en_i,
    input  logic mode_ew1_i,
    input  logic req_wr_en_i,
    input  logic req_wr_val_i,
    input  logic irq_pend_i,
    input  logic erase_start_i,
    input  logic erase_done_i,
    output logic pause_o,
    output logic susp_stat_o,
    output logic flash_acc_ok_o,
    output logic req_bit_o
);
    import esc_pkg::*;

    esc_state_e state;
    logic       hw_set, req_next, set_evt;

    assign hw_set = mode_ew1_i & irq_pend_i & susp_en_i & (state == ST_ERASE);

    esc_req_reg u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (req_wr_en_i),
        .wr_val_i   (req_wr_val_i),
        .hw_set_i   (hw_set),
        .req_next_o (req_next),
        .set_evt_o  (set_evt),
        .req_q_o    (req_bit_o)
    );

    esc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (erase_start_i),
        .done_i     (erase_done_i),
        .susp_en_i  (susp_en_i),
        .set_evt_i  (set_evt),
        .req_next_i (req_next),
        .state_o    (state)
    );

    assign pause_o        = (state == ST_SUSP);
    assign susp_stat_o    = (state != ST_ERASE);
    assign flash_acc_ok_o = (state != ST_ERASE);
endmodule

// File: rtl/esc_chk.sv
module esc_chk (
    input logic clk,
    input logic rst_n,
    input logic susp_en_i,
    input logic mode_ew1_i,
    input logic req_wr_en_i,
    input logic req_wr_val_i,
    input logic irq_pend_i,
    input logic erase_start_i,
    input logic erase_done_i,
    input logic pause_o,
    input logic susp_stat_o,
    input logic req_bit_o
);
    p_pause_stat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |-> susp_stat_o);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_stat_o && !pause_o && erase_start_i) |=> !susp_stat_o);

    p_sw_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!susp_stat_o && susp_en_i && req_wr_en_i && req_wr_val_i && !erase_done_i)
        |=> pause_o);

    p_irq_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!susp_stat_o && susp_en_i && mode_ew1_i && irq_pend_i && !erase_done_i)
        |=> (pause_o && req_bit_o));

    p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o && req_wr_en_i && !req_wr_val_i) |=> (!pause_o && !susp_stat_o));

    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!susp_en_i && !susp_stat_o) |=> !pause_o);

    p_ew0_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ew1_i && !req_wr_en_i) |=> $stable(req_bit_o));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o && !(req_wr_en_i && !req_wr_val_i)) |=> pause_o);
endmodule

bind erase_susp_ctrl esc_chk u_esc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .susp_en_i     (susp_en_i),
    .mode_ew1_i    (mode_ew1_i),
    .req_wr_en_i   (req_wr_en_i),
    .req_wr_val_i  (req_wr_val_i),
    .irq_pend_i    (irq_pend_i),
    .erase_start_i (erase_start_i),
    .erase_done_i  (erase_done_i),
    .pause_o       (pause_o),
    .susp_stat_o   (susp_stat_o),
    .req_bit_o     (req_bit_o)
);

// File: tb/tb_erase_susp_ctrl.sv
module tb_erase_susp_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic susp_en_i = 0, mode_ew1_i = 0, req_wr_en_i = 0, req_wr_val_i = 0;
    logic irq_pend_i = 0, erase_start_i = 0, erase_done_i = 0;
    logic pause_o, susp_stat_o, flash_acc_ok_o, req_bit_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    erase_susp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .susp_en_i(susp_en_i), .mode_ew1_i(mode_ew1_i),
        .req_wr_en_i(req_wr_en_i), .req_wr_val_i(req_wr_val_i), .irq_pend_i(irq_pend_i),
        .erase_start_i(erase_start_i), .erase_done_i(erase_done_i), .pause_o(pause_o),
        .susp_stat_o(susp_stat_o), .flash_acc_ok_o(flash_acc_ok_o), .req_bit_o(req_bit_o)
    );

    // inputs {en,ew1,wen,wval,irq,start,done}, expected {pause,stat,acc,req}
    localparam int NV = 20;
    localparam logic [10:0] VEC [NV] = '{
        11'b1000010_0000,  // R2 start erase
        11'b1011000_1111,  // R3 sw suspend
        11'b1000001_1111,  // R9 done ignored
        11'b1000010_1111,  // R9 start ignored
        11'b1010000_0000,  // R5 resume
        11'b1000100_0000,  // R8 irq in EW0
        11'b0011000_0001,  // R6 disabled sw write
        11'b1010000_0000,  // R6 clear, still erasing
        11'b1100100_1111,  // R4 irq suspend
        11'b1110000_0000,  // R5 resume in EW1
        11'b0100100_0000,  // R6 disabled irq
        11'b1110100_1111,  // R10 hw set beats clear
        11'b1010000_0000,  // R5 resume
        11'b1000001_0110,  // R2 erase done
        11'b1011000_0111,  // R7 write in idle
        11'b1100100_0111,  // R7 irq in idle
        11'b1010000_0110,  // R7 clear in idle
        11'b1000001_0110,  // R2 done in idle
        11'b1000010_0000,  // R2 start again
        11'b1011001_0111   // R2 done beats suspend
    };
    localparam int VREQ [NV] = '{2,3,9,9,5,8,6,6,4,5,6,10,5,2,7,7,7,2,2,2};

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {pause_o, susp_stat_o, flash_acc_ok_o, req_bit_o};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {pause,stat,acc,req} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        {susp_en_i, mode_ew1_i, req_wr_en_i, req_wr_val_i,
         irq_pend_i, erase_start_i, erase_done_i} = v;
    endtask

    initial begin
        #2000;
        if (!done_flag) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 during reset", 4'b0110);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 4'b0110);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][10:4]);
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VREQ[i], i), VEC[i][3:0]);
        end
        // directed: reset while suspended returns to idle (R1)
        drive(7'b1000010); @(negedge clk);
        drive(7'b1011000); @(negedge clk);
        check("R3 directed suspend", 4'b1111);
        drive(7'b0);
        rst_n = 1'b0; #1;
        check("R1 reset mid-suspend", 4'b0110);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", 4'b0110);
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule